// File: doc/BRIEF.md
# Snooped Bus Cycle Qualifier

This block sits between the address decode of a split-transaction processor bus and a memory controller's datapath. It decides whether a decoded cycle may move data. Two late inputs shape that decision. The first is a hold-off from a look-aside second-level cache, which can claim a cycle for itself. The second is an address-retry signal from snooping caches, which can cancel a main-memory cycle after the memory access may already have begun.

The block reports its decision through three registered strobes. A one-cycle `respond` pulse releases the memory cycle. A one-cycle `killRead` or `killWrite` pulse tells the datapath not to return the read data, or not to commit the write data. The memory array may still be cycled, because cancellation acts only on the data transfer. A fourth strobe, `globalErr`, flags a coherent attribute on a register-space cycle, since coherency is kept for main memory only.

Every input is active-low and passes through one register stage. The retry window length is set by the parameter `RETRY_WIN`, which defaults to 2. The bench instantiates the block with a window of 3 so that the part of the window after the hold-off sample is also exercised.

Top module: `snoopCycleQualifier`

## Requirements
- R1: While `rstN` is low, and after its release until a cycle is accepted, `respond`, `killRead`, `killWrite` and `globalErr` are all low.
- R2: A cycle is accepted when `xferStartN` is sampled low at a rising edge E while the block is idle and `memSelN` or `regSelN` is low. If both are low, the cycle is a memory cycle. `cacheHoldN` is sampled at edge E+1. If it is high, `respond` is high for exactly the one cycle that follows edge E+2.
- R3: If `cacheHoldN` is low at edge E+1, the cycle is ignored: no `respond`, no kill strobe, and a new start sampled at edge E+2 is accepted.
- R4: For a memory read (`writeN` high at edge E), `retryN` low at any edge from E to E+RETRY_WIN-1 gives one `killRead` pulse after edge max(R+1, E+2), where R is the first retry edge. `killWrite` stays low.
- R5: For a memory write (`writeN` low at edge E), the same retry gives one `killWrite` pulse at the same time, and `killRead` stays low.
- R6: A `retryN` low seen at edge E+RETRY_WIN or later has no effect on that cycle.
- R7: Retry is ignored on register-space cycles (`regSelN` low, `memSelN` high). `respond` is still given when the hold-off sample is high.
- R8: `globalN` low at edge E on a register-space cycle gives one `globalErr` pulse after edge E+1. On a memory cycle, `globalN` low raises no error.
- R9: After a retried cycle, a start sampled at the edge that raises the kill strobe is accepted. After a cycle with no retry, a start sampled at edge E+max(RETRY_WIN,2) is accepted.
- R10: A start sampled while a cycle is still in progress is ignored. A start with both selects high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xferStartN | input | 1 | Transfer-start strobe, active low |
| memSelN | input | 1 | Main-memory address hit, active low |
| regSelN | input | 1 | Register-space address hit, active low |
| writeN | input | 1 | Direction, low means write |
| globalN | input | 1 | Coherent (global) attribute, active low |
| cacheHoldN | input | 1 | Second-level cache hold-off, low claims the cycle |
| retryN | input | 1 | Snoop address retry, active low |
| respond | output | 1 | One-cycle pulse: the cycle is handled by this controller |
| killRead | output | 1 | One-cycle pulse: do not drive read data for this cycle |
| killWrite | output | 1 | One-cycle pulse: do not commit write data for this cycle |
| globalErr | output | 1 | One-cycle pulse: coherent attribute on a register-space cycle |

## Verification
A stuck or mistimed sequencer state shows at the ports within three clocks of a start. It appears as a `respond` pulse shifted by one edge, a missing or doubled pulse, or a kill strobe on the wrong direction. A window counter that is off by one shows as a kill from a retry one edge too late, or a missing kill one edge inside the window. A busy state that is held too long or released too early shows on the next back-to-back start, which is either dropped or wrongly accepted. The bench therefore compares every output on every clock against an independent timeline model.

// File: rtl/snoopQualPkg.sv
package snoopQualPkg;

  // bit positions inside the packed raw input vector
  localparam int IDX_START = 0;
  localparam int IDX_MEM   = 1;
  localparam int IDX_REG   = 2;
  localparam int IDX_WR    = 3;
  localparam int IDX_GBL   = 4;
  localparam int IDX_HOLD  = 5;
  localparam int IDX_RETRY = 6;
  localparam int IN_W      = 7;

  // registered bus view, active-high
  typedef struct packed {
    logic start;
    logic memHit;
    logic regHit;
    logic isWrite;
    logic isGlobal;
    logic holdOk;
    logic retry;
  } busIn_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic latch;
    logic respond;
    logic kill;
    logic flagErr;
  } ctrlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_WINDOW = 2'd2
  } qualState_e;

endpackage

// File: rtl/qualDatapath.sv
module qualDatapath
  import snoopQualPkg::*;
#(
  parameter int IN_BITS = IN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IN_BITS-1:0] rawN,
  input  ctrlStrb_t          strb,
  output busIn_t             bus,
  output logic               attrMem,
  output logic               attrWrite,
  output logic               respond,
  output logic               killRead,
  output logic               killWrite,
  output logic               globalErr
);

  logic [IN_BITS-1:0] syncN;

  // one register per input, reset to the inactive (high) level
  for (genvar i = 0; i < IN_BITS; i++) begin : g_inReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncN[i] <= 1'b1;
      else       syncN[i] <= rawN[i];
    end
  end

  // decode to active-high; memory hit wins over register hit
  always_comb begin
    bus.start    = ~syncN[IDX_START];
    bus.memHit   = ~syncN[IDX_MEM];
    bus.regHit   = ~syncN[IDX_REG] & syncN[IDX_MEM];
    bus.isWrite  = ~syncN[IDX_WR];
    bus.isGlobal = ~syncN[IDX_GBL];
    bus.holdOk   = syncN[IDX_HOLD];
    bus.retry    = ~syncN[IDX_RETRY];
  end

  // per-cycle attributes captured at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrMem   <= 1'b0;
      attrWrite <= 1'b0;
    end else if (strb.latch) begin
      attrMem   <= bus.memHit;
      attrWrite <= bus.isWrite;
    end
  end

  // registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respond   <= 1'b0;
      killRead  <= 1'b0;
      killWrite <= 1'b0;
      globalErr <= 1'b0;
    end else begin
      respond   <= strb.respond;
      killRead  <= strb.kill & ~attrWrite;
      killWrite <= strb.kill & attrWrite;
      globalErr <= strb.flagErr;
    end
  end

endmodule

// File: rtl/qualCtrl.sv
module qualCtrl
  import snoopQualPkg::*;
#(
  parameter int RETRY_WIN = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  busIn_t    bus,
  input  logic      attrMem,
  output ctrlStrb_t strb,
  output logic      holdPhase
);

  localparam int CNT_RAW = $clog2(RETRY_WIN + 1);
  localparam int CNT_W   = (CNT_RAW < 2) ? 2 : CNT_RAW;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RETRY_WIN - 1);
  localparam bit HOLD_IN_WIN = (RETRY_WIN >= 2);
  localparam bit HAS_TAIL    = (RETRY_WIN > 2);

  qualState_e       state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             pendKill, pendNx;
  logic             retryNow;

  always_comb begin
    stateNx  = state;
    cntNx    = cnt;
    pendNx   = pendKill;
    strb     = '0;
    retryNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (bus.start && (bus.memHit || bus.regHit)) begin
          strb.latch   = 1'b1;
          strb.flagErr = bus.regHit & bus.isGlobal;
          pendNx       = bus.memHit & bus.retry;
          cntNx        = CNT_W'(1);
          stateNx      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        retryNow = HOLD_IN_WIN & attrMem & bus.retry;
        pendNx   = 1'b0;
        if (!bus.holdOk) begin
          stateNx = ST_IDLE;
        end else begin
          strb.respond = 1'b1;
          if (pendKill || retryNow) begin
            strb.kill = 1'b1;
            stateNx   = ST_IDLE;
          end else if (HAS_TAIL) begin
            cntNx   = CNT_W'(2);
            stateNx = ST_WINDOW;
          end else begin
            stateNx = ST_IDLE;
          end
        end
      end
      ST_WINDOW: begin
        retryNow = attrMem & bus.retry;
        if (retryNow) begin
          strb.kill = 1'b1;
          stateNx   = ST_IDLE;
        end else if (cnt == LAST_IDX) begin
          stateNx = ST_IDLE;
        end else begin
          cntNx = cnt + CNT_W'(1);
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pendKill <= 1'b0;
    end else begin
      state    <= stateNx;
      cnt      <= cntNx;
      pendKill <= pendNx;
    end
  end

  assign holdPhase = (state == ST_HOLD);

endmodule

// File: rtl/snoopCycleQualifier.sv
module snoopCycleQualifier
  import snoopQualPkg::*;
#(
  parameter int RETRY_WIN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic xferStartN,
  input  logic memSelN,
  input  logic regSelN,
  input  logic writeN,
  input  logic globalN,
  input  logic cacheHoldN,
  input  logic retryN,
  output logic respond,
  output logic killRead,
  output logic killWrite,
  output logic globalErr
);

  logic [IN_W-1:0] rawN;
  busIn_t          bus;
  ctrlStrb_t       strb;
  logic            attrMem;
  logic            attrWrite;
  logic            holdPhase;

  always_comb begin
    rawN            = '1;
    rawN[IDX_START] = xferStartN;
    rawN[IDX_MEM]   = memSelN;
    rawN[IDX_REG]   = regSelN;
    rawN[IDX_WR]    = writeN;
    rawN[IDX_GBL]   = globalN;
    rawN[IDX_HOLD]  = cacheHoldN;
    rawN[IDX_RETRY] = retryN;
  end

  qualDatapath #(.IN_BITS(IN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rawN      (rawN),
    .strb      (strb),
    .bus       (bus),
    .attrMem   (attrMem),
    .attrWrite (attrWrite),
    .respond   (respond),
    .killRead  (killRead),
    .killWrite (killWrite),
    .globalErr (globalErr)
  );

  qualCtrl #(.RETRY_WIN(RETRY_WIN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bus       (bus),
    .attrMem   (attrMem),
    .strb      (strb),
    .holdPhase (holdPhase)
  );

endmodule

// File: rtl/snoopQualChk.sv
module snoopQualChk (
  input logic clk,
  input logic rstN,
  input logic respond,
  input logic killRead,
  input logic killWrite,
  input logic globalErr,
  input logic holdPhase,
  input logic holdOk,
  input logic attrMem
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!respond && !killRead && !killWrite && !globalErr)
        else $error("outputs active during reset");
    end
  end

  // R2
  respond_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respond |=> !respond);

  // R3
  holdoff_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdPhase && !holdOk) |=> (!respond && !killRead && !killWrite));

  // R4
  kill_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(killRead && killWrite));

  // R7
  kill_mem_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (killRead || killWrite) |-> $past(attrMem));

  // R9
  kill_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (killRead || killWrite) |=> !(killRead || killWrite));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    globalErr |=> !globalErr);

endmodule

bind snoopCycleQualifier snoopQualChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .respond   (respond),
  .killRead  (killRead),
  .killWrite (killWrite),
  .globalErr (globalErr),
  .holdPhase (holdPhase),
  .holdOk    (bus.holdOk),
  .attrMem   (attrMem)
);

// File: tb/snoopCycleQualifier_tb.sv
`timescale 1ns/1ps
module snoopCycleQualifier_tb;

  localparam int WIN  = 3;
  localparam int MAXW = (WIN > 2) ? WIN : 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xferStartN = 1'b1, memSelN = 1'b1, regSelN = 1'b1, writeN = 1'b1;
  logic globalN = 1'b1, cacheHoldN = 1'b1, retryN = 1'b1;
  logic respond, killRead, killWrite, globalErr;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  snoopCycleQualifier #(.RETRY_WIN(WIN)) u_dut (
    .clk(clk), .rstN(rstN), .xferStartN(xferStartN), .memSelN(memSelN),
    .regSelN(regSelN), .writeN(writeN), .globalN(globalN),
    .cacheHoldN(cacheHoldN), .retryN(retryN), .respond(respond),
    .killRead(killRead), .killWrite(killWrite), .globalErr(globalErr)
  );

  // behavioural timeline model: expected pulses keyed by edge number
  bit expR[int], expKR[int], expKW[int], expE[int];
  int n = 0, s = 0, freeAt = 0;
  bit act = 0, tMem = 0, tWr = 0, pend = 0;

  always @(posedge clk) begin
    if (rstN) begin
      int off;
      n = n + 1;
      if (act) begin
        off = n - s;
        if (off == 1) begin
          if (cacheHoldN == 1'b0) begin
            act = 0; freeAt = n + 1;
          end else begin
            expR[n+1] = 1;
            if (pend || (tMem && !retryN && 1 < WIN)) begin
              if (tWr) expKW[n+1] = 1; else expKR[n+1] = 1;
              act = 0; freeAt = n + 1;
            end
          end
        end else if (tMem && !retryN && off < WIN) begin
          if (tWr) expKW[n+1] = 1; else expKR[n+1] = 1;
          act = 0; freeAt = n + 1;
        end
        if (act && off >= MAXW - 1) begin
          act = 0; freeAt = n + 1;
        end
      end
      if (!act && n >= freeAt && !xferStartN && (!memSelN || !regSelN)) begin
        act = 1; s = n;
        tMem = !memSelN;
        tWr = !writeN;
        pend = tMem && !retryN;
        if (!tMem && !globalN) expE[n+1] = 1;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit eR, eKR, eKW, eE;
      eR  = rstN && expR.exists(n);
      eKR = rstN && expKR.exists(n);
      eKW = rstN && expKW.exists(n);
      eE  = rstN && expE.exists(n);
      compared++;
      if ({respond, killRead, killWrite, globalErr} !== {eR, eKR, eKW, eE}) begin
        mismatched++;
        $display("FAIL %s edge %0d: actual resp/kR/kW/err=%b%b%b%b expected %b%b%b%b",
                 curReq, n, respond, killRead, killWrite, globalErr, eR, eKR, eKW, eE);
      end
    end
  end

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      xferStartN = 1'b1; memSelN = 1'b1; regSelN = 1'b1; writeN = 1'b1;
      globalN = 1'b1; cacheHoldN = 1'b1; retryN = 1'b1;
    end
  endtask

  // one cycle at offset 0, optional second start (memory read) at nextOff
  task automatic runTx(input string tag, input bit mem, input bit rg,
                       input bit wr, input bit glob, input bit holdOk,
                       input int retryOff, input int nextOff);
    curReq = tag;
    for (int o = 0; o < 8; o++) begin
      @(negedge clk);
      xferStartN = !(o == 0 || o == nextOff);
      memSelN    = !((o == 0 && mem) || o == nextOff);
      regSelN    = !(o == 0 && rg);
      writeN     = !(o == 0 && wr);
      globalN    = !(o == 0 && glob);
      cacheHoldN = !(o == 1 && !holdOk);
      retryN     = !(o == retryOff);
    end
    idle(4);
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(3);
    // R2: memory read, hold-off high, no retry
    runTx("R2", 1, 0, 0, 0, 1, -1, -1);
    // R2: register read, and both selects low (memory wins)
    runTx("R2", 0, 1, 0, 0, 1, -1, -1);
    runTx("R2", 1, 1, 1, 0, 1, -1, -1);
    // R3: hold-off low ignores cycle and its retry; restart at offset 2
    runTx("R3", 1, 0, 0, 0, 0, 0, 2);
    // R4: read retried at offsets 1 and 0
    runTx("R4", 1, 0, 0, 0, 1, 1, -1);
    runTx("R4", 1, 0, 0, 0, 1, 0, -1);
    // R5: write retried in the tail of the window, and at offset 1
    runTx("R5", 1, 0, 1, 0, 1, 2, -1);
    runTx("R5", 1, 0, 1, 0, 1, 1, -1);
    // R6: retry just after the window closes
    runTx("R6", 1, 0, 1, 0, 1, 3, -1);
    runTx("R6", 1, 0, 0, 0, 1, 4, -1);
    // R7: register-space cycles ignore retry
    runTx("R7", 0, 1, 1, 0, 1, 1, -1);
    runTx("R7", 0, 1, 0, 0, 1, 0, -1);
    // R8: coherent attribute on register space flags, on memory does not
    runTx("R8", 0, 1, 0, 1, 1, -1, -1);
    runTx("R8", 1, 0, 0, 1, 1, -1, -1);
    // R9: back-to-back acceptance after retry and after a full window
    runTx("R9", 1, 0, 0, 0, 1, 1, 2);
    runTx("R9", 1, 0, 1, 0, 1, 2, 3);
    runTx("R9", 1, 0, 0, 0, 1, -1, 3);
    // R10: start while busy, and a start with no select
    runTx("R10", 1, 0, 0, 0, 1, -1, 1);
    runTx("R10", 1, 0, 0, 0, 1, -1, 2);
    runTx("R10", 0, 0, 0, 0, 1, 1, -1);
    idle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL %s watchdog expired: actual hung expected finished", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule